// File: doc/BRIEF.md
# Self-Clocking Read Clock/Data Separator

This block takes a double-frequency read-pulse stream that has no separate timing track and recovers from it the cell timing and the data bits. Every cell opens with a clock pulse. A second pulse half a cell later marks a one, and no second pulse marks a zero. The block runs on a fast system clock and models a voltage-controlled oscillator loop in digital logic. A phase accumulator ticks at twice the cell rate, and a toggle flop divides those ticks into alternating clock and data windows. A strobe sits in the middle of each clock window, and a copy of it delayed by one cycle closes the loop through a two-flop phase detector with a proportional-integral correction.

The block starts in an acquisition phase and admits every read pulse as a clock pulse. This lets it pull in on the preamble of zeros, in which each pulse is a clock pulse. After a run of consecutive clock pulses that all fall inside the clock window, it declares lock. From then on only pulses inside the clock window steer the loop, and pulses inside the data window become ones. If the clock pulses disappear, lock drops and acquisition starts again. When read mode is off, the oscillator free-runs at its nominal rate, which gives fixed timing for writing.

Top module: `data_separator`

## Requirements
- R1: While reset is held and immediately after it, `locked_o`, `bit_vld_o`, `bit_o` and `clk_strobe_o` are all 0.
- R2: With `rd_en` high, `locked_o` rises only after LOCK_CNT (default 256) consecutive read pulses have landed inside the clock window. Fewer pulses never give lock, and a steady preamble of zeros at a 20-cycle cell does give lock.
- R3: Once locked, `bit_vld_o` pulses for one cycle at the end of each data window. `bit_o` is then 1 if a read pulse arrived inside that data window and 0 otherwise. `bit_vld_o` is only ever high in the cycle after a cycle in which `locked_o` was high.
- R4: After lock, pulses inside the data window do not feed the loop, so a long run of ones, with two pulses in every cell, keeps lock and decodes as all ones.
- R5: When locked, the loop follows a cell rate about 0.6 % slower than nominal, with pulse jitter of up to ±2 cycles, and still decodes every bit correctly.
- R6: After lock, four consecutive clock windows without a clock pulse drop `locked_o`. Up to three missed windows keep lock.
- R7: After lock is lost, regaining it needs a new full run of LOCK_CNT in-window clock pulses.
- R8: While `rd_en` is low, read pulses are ignored. `locked_o` and `bit_vld_o` stay 0, and `clk_strobe_o` repeats every 19 or 20 cycles from the nominal increment alone.
- R9: `clk_strobe_o` is a one-cycle pulse, once per cell, in the middle of the clock window. When locked, it lands within ±3 cycles of the separated clock pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System (oversampling) clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Read mode; low selects fixed nominal timing |
| rd_pulse | input | 1 | One-cycle pulse per detected flux transition |
| clk_strobe_o | output | 1 | Recovered cell strobe, centred in the clock window |
| bit_o | output | 1 | Recovered data bit, valid with `bit_vld_o` |
| bit_vld_o | output | 1 | One-cycle bit strobe at the end of each data window |
| locked_o | output | 1 | Loop has acquired and is in gated mode |

## Verification
The bench goes after the lock threshold. After 250 preamble pulses the block must still be unlocked; a counter that is short by a few would show lock too early, and one that never completes would leave the later checks starved. An all-ones run checks that data-window pulses stay out of the loop: a design that let them through would see a doubled pulse rate, slip phase and decode wrong bits or lose lock. A silent stretch and a resumed preamble check the four-window lock-loss rule and the full re-acquisition; a design that dropped lock early or carried the old count over would be caught. Read mode held low with pulses at a foreign rate checks that the oscillator keeps its nominal period and never locks.

// File: rtl/sep_pkg.sv
package sep_pkg;

    // State of the divide-by-two window flop
    typedef enum logic {
        WIN_CLK = 1'b0,
        WIN_DAT = 1'b1
    } win_e;

endpackage

// File: rtl/sep_nco.sv
// Phase accumulator at twice the cell rate, window divider and centred strobe.
module sep_nco
    import sep_pkg::*;
#(
    parameter int ACC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] inc_i,
    output logic             clk_win_o,
    output logic             clk_end_o,
    output logic             dat_end_o,
    output logic             strobe_o,
    output logic             sync_o
);

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        win_e             win;
        logic             stb;
        logic             sync;
    } nco_s;

    nco_s q, d;
    logic [ACC_W:0] sum;
    logic           carry;
    logic           mid;

    always_comb begin
        d     = q;
        sum   = {1'b0, q.acc} + {1'b0, inc_i};
        carry = sum[ACC_W];
        // half-way crossing of the accumulator marks the middle of a window
        mid   = !carry && !q.acc[ACC_W-1] && sum[ACC_W-1];
        d.acc = sum[ACC_W-1:0];
        if (carry) d.win = (q.win == WIN_CLK) ? WIN_DAT : WIN_CLK;
        d.stb  = mid && (q.win == WIN_CLK);
        d.sync = q.stb;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{acc: '0, win: WIN_CLK, stb: 1'b0, sync: 1'b0};
        else        q <= d;
    end

    assign clk_win_o = (q.win == WIN_CLK);
    assign clk_end_o = carry && (q.win == WIN_CLK);
    assign dat_end_o = carry && (q.win == WIN_DAT);
    assign strobe_o  = q.stb;
    assign sync_o    = q.sync;

endmodule

// File: rtl/sep_pd.sv
// Two set-only flops as phase detector, followed by a saturating PI filter.
module sep_pd #(
    parameter int ACC_W   = 16,
    parameter int NOM_INC = 6554,
    parameter int KP      = 11,
    parameter int KI      = 6,
    parameter int INT_W   = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             sync_i,
    input  logic             cpulse_i,
    output logic [ACC_W-1:0] inc_o
);

    localparam int CW     = ACC_W + 2;
    localparam int IMAX_I = (1 << (INT_W - 1)) - 1;
    localparam logic signed [CW-1:0]  ONE  = CW'(1);
    localparam logic signed [INT_W:0] IMAX = (INT_W+1)'(IMAX_I);

    typedef struct packed {
        logic                    a;     // set by local sync strobe
        logic                    b;     // set by separated disk clock
        logic signed [INT_W-1:0] integ;
    } pd_s;

    pd_s q, d;
    logic signed [CW-1:0]  err_w, int_w, corr_w, inc_w;
    logic signed [INT_W:0] isum;

    always_comb begin
        d = q;
        // b alone high: disk ahead, speed up; a alone high: slow down
        err_w  = q.b ? ONE : (q.a ? -ONE : '0);
        int_w  = CW'(q.integ);
        corr_w = (err_w <<< KP) + (int_w >>> KI);
        inc_w  = CW'(NOM_INC) + corr_w;

        d.a = q.a | sync_i;
        d.b = q.b | cpulse_i;
        if (d.a && d.b) begin
            d.a = 1'b0;
            d.b = 1'b0;
        end

        isum = (INT_W+1)'(q.integ) + (INT_W+1)'(err_w);
        if (isum > IMAX)       d.integ = INT_W'(IMAX);
        else if (isum < -IMAX) d.integ = INT_W'(-IMAX);
        else                   d.integ = INT_W'(isum);

        if (!en_i) d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign inc_o = en_i ? ACC_W'(inc_w) : ACC_W'(NOM_INC);

endmodule

// File: rtl/sep_slicer.sv
// Pulse catcher, acquisition/lock control and data-bit capture.
module sep_slicer #(
    parameter int CATCH_W  = 5,
    parameter int LOCK_CNT = 256,
    parameter int MISS_LIM = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic rd_pulse_i,
    input  logic clk_win_i,
    input  logic clk_end_i,
    input  logic dat_end_i,
    output logic cpulse_o,
    output logic locked_o,
    output logic bit_o,
    output logic bit_vld_o
);

    localparam int CT_W = $clog2(CATCH_W + 1);
    localparam int LC_W = $clog2(LOCK_CNT + 1);
    localparam int ML_W = $clog2(MISS_LIM + 1);

    typedef struct packed {
        logic [CT_W-1:0] catch_cnt;
        logic            cp;
        logic            lock;
        logic [LC_W-1:0] acq;
        logic [ML_W-1:0] miss;
        logic            seen;
        logic            bit_acc;
        logic            bit_out;
        logic            vld;
    } sl_s;

    sl_s  q, d;
    logic admit;
    logic pulse_clk;
    logic pulse_dat;

    always_comb begin
        d         = q;
        d.cp      = 1'b0;
        d.vld     = 1'b0;
        pulse_clk = rd_pulse_i && clk_win_i;
        pulse_dat = rd_pulse_i && !clk_win_i;
        admit     = rd_pulse_i && (!q.lock || clk_win_i);

        // self-clearing catcher: one bounded detector pulse per admitted pulse
        if (q.catch_cnt != '0) d.catch_cnt = q.catch_cnt - 1'b1;
        else if (admit) begin
            d.catch_cnt = CT_W'(CATCH_W);
            d.cp        = 1'b1;
        end

        if (!q.lock) begin
            d.bit_acc = 1'b0;
            if (pulse_clk) begin
                if (q.acq == LC_W'(LOCK_CNT - 1)) begin
                    d.lock = 1'b1;
                    d.acq  = '0;
                    d.miss = '0;
                    d.seen = 1'b0;
                end else begin
                    d.acq = q.acq + 1'b1;
                end
            end else if (pulse_dat) begin
                d.acq = '0;
            end
        end else begin
            if (pulse_clk) d.seen = 1'b1;
            if (pulse_dat) d.bit_acc = 1'b1;
            if (clk_end_i) begin
                d.seen = 1'b0;
                if (q.seen || pulse_clk) d.miss = '0;
                else if (q.miss == ML_W'(MISS_LIM - 1)) begin
                    d.lock = 1'b0;
                    d.miss = '0;
                    d.acq  = '0;
                end else begin
                    d.miss = q.miss + 1'b1;
                end
            end
        end

        if (dat_end_i) begin
            d.vld     = q.lock;
            d.bit_out = q.bit_acc | (q.lock && pulse_dat);
            d.bit_acc = 1'b0;
        end

        if (!en_i) d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cpulse_o  = q.cp;
    assign locked_o  = q.lock;
    assign bit_o     = q.bit_out;
    assign bit_vld_o = q.vld;

endmodule

// File: rtl/data_separator.sv
module data_separator #(
    parameter int SYS_HZ   = 100_000_000,
    parameter int TICK_HZ  = 10_000_000,
    parameter int ACC_W    = 16,
    parameter int KP       = 11,
    parameter int KI       = 6,
    parameter int INT_W    = 12,
    parameter int CATCH_W  = 5,
    parameter int LOCK_CNT = 256,
    parameter int MISS_LIM = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_en,
    input  logic rd_pulse,
    output logic clk_strobe_o,
    output logic bit_o,
    output logic bit_vld_o,
    output logic locked_o
);

    // nominal increment: tick at twice the cell rate, rounded
    localparam int NOM_INC = int'(((longint'(1) << ACC_W) * longint'(TICK_HZ)
                                   + longint'(SYS_HZ / 2)) / longint'(SYS_HZ));

    logic [ACC_W-1:0] inc;
    logic clk_win, clk_end, dat_end, sync, cpulse;

    sep_nco #(.ACC_W(ACC_W)) u_nco (
        .clk       (clk),
        .rst_n     (rst_n),
        .inc_i     (inc),
        .clk_win_o (clk_win),
        .clk_end_o (clk_end),
        .dat_end_o (dat_end),
        .strobe_o  (clk_strobe_o),
        .sync_o    (sync)
    );

    sep_pd #(
        .ACC_W(ACC_W), .NOM_INC(NOM_INC), .KP(KP), .KI(KI), .INT_W(INT_W)
    ) u_pd (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (rd_en),
        .sync_i   (sync),
        .cpulse_i (cpulse),
        .inc_o    (inc)
    );

    sep_slicer #(
        .CATCH_W(CATCH_W), .LOCK_CNT(LOCK_CNT), .MISS_LIM(MISS_LIM)
    ) u_slicer (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (rd_en),
        .rd_pulse_i (rd_pulse),
        .clk_win_i  (clk_win),
        .clk_end_i  (clk_end),
        .dat_end_i  (dat_end),
        .cpulse_o   (cpulse),
        .locked_o   (locked_o),
        .bit_o      (bit_o),
        .bit_vld_o  (bit_vld_o)
    );

endmodule

// File: rtl/sep_chk.sv
module sep_chk (
    input logic clk,
    input logic rst_n,
    input logic rd_en,
    input logic rd_pulse,
    input logic clk_strobe_o,
    input logic bit_vld_o,
    input logic locked_o
);

    AST_LOCK_ON_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked_o) |-> $past(rd_pulse)); // R2

    AST_VLD_AFTER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        bit_vld_o |-> $past(locked_o)); // R3

    AST_VLD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        bit_vld_o |=> !bit_vld_o); // R3

    AST_LOCK_DROP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(locked_o) |-> $past(!rd_pulse || !rd_en)); // R6

    AST_IDLE_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !locked_o); // R8

    AST_IDLE_NO_VLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !bit_vld_o); // R8

    AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        clk_strobe_o |=> !clk_strobe_o); // R9

endmodule

bind data_separator sep_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_en        (rd_en),
    .rd_pulse     (rd_pulse),
    .clk_strobe_o (clk_strobe_o),
    .bit_vld_o    (bit_vld_o),
    .locked_o     (locked_o)
);

// File: tb/sim_data_separator.sv
module sim_data_separator;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rd_en = 1'b0;
    logic rd_pulse = 1'b0;
    logic clk_strobe_o, bit_o, bit_vld_o, locked_o;

    int  checks = 0;
    int  errors = 0;
    int  cyc = 0;
    int  last_stb = -1000;
    int  prev_stb = -1;
    int  idle_vld = 0;
    bit  idle_chk = 1'b0;
    bit  done = 1'b0;
    logic [7:0] lf = 8'hA5;
    bit  exp_q[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    data_separator u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .rd_en        (rd_en),
        .rd_pulse     (rd_pulse),
        .clk_strobe_o (clk_strobe_o),
        .bit_o        (bit_o),
        .bit_vld_o    (bit_vld_o),
        .locked_o     (locked_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp_v);
        end
    endtask

    // monitor: strobe timing and scoreboard of recovered bits
    always @(negedge clk) begin
        if (clk_strobe_o) begin
            if (idle_chk && prev_stb >= 0)
                chk((cyc - prev_stb) == 19 || (cyc - prev_stb) == 20,
                    "R8 idle strobe interval", cyc - prev_stb, 20);
            prev_stb = cyc;
            last_stb = cyc;
        end
        if (bit_vld_o) begin
            if (!rd_en) idle_vld++;
            if (exp_q.size() > 0) begin
                bit e;
                e = exp_q.pop_front();
                chk(bit_o == e, "R3 recovered bit", int'(bit_o), int'(e));
            end
        end
    end

    function automatic void lf_step();
        lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
    endfunction

    // driver: one cell, clock pulse near its start, data pulse half a cell later
    task automatic drive_cell(input bit dat, input int per, input int jc,
                              input int jd, input bit push, input bit algn);
        int k_clk = -100;
        for (int i = 0; i < per; i++) begin
            @(negedge clk);
            if (push && i == 0) exp_q.push_back(dat);
            rd_pulse = (i == 2 + jc) || (dat && i == 12 + jd);
            if (i == 2 + jc) k_clk = cyc;
            if (algn && i == 8)
                chk(last_stb >= k_clk - 3 && last_stb <= k_clk + 3,
                    "R9 strobe centred on clock pulse", last_stb, k_clk);
        end
    endtask

    task automatic preamble(input int n);
        for (int c = 0; c < n; c++) drive_cell(1'b0, 20, 0, 0, 1'b0, 1'b0);
    endtask

    task automatic quiet(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rd_pulse = 1'b0;
        end
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(!locked_o && !bit_vld_o && !bit_o && !clk_strobe_o, "R1 during reset",
            int'({locked_o, bit_vld_o, bit_o, clk_strobe_o}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!locked_o && !bit_vld_o && !bit_o, "R1 after reset",
            int'({locked_o, bit_vld_o, bit_o}), 0);

        // R8: read mode off, pulses at a foreign 17-cycle rate are ignored
        idle_chk = 1'b1;
        for (int c = 0; c < 40; c++) begin
            for (int i = 0; i < 17; i++) begin
                @(negedge clk);
                rd_pulse = (i == 3);
            end
        end
        idle_chk = 1'b0;
        chk(!locked_o, "R8 no lock while idle", int'(locked_o), 0);
        chk(idle_vld == 0, "R8 no bit strobe while idle", idle_vld, 0);

        // R2: acquisition on a preamble of zeros
        rd_en = 1'b1;
        preamble(250);
        chk(!locked_o, "R2 no lock before full count", int'(locked_o), 0);
        preamble(200);
        chk(locked_o, "R2 lock after preamble", int'(locked_o), 1);
        preamble(20);

        // R3 and R9: random bits at nominal rate
        for (int c = 0; c < 100; c++) begin
            lf_step();
            drive_cell(lf[0], 20, 0, 0, 1'b1, 1'b1);
        end

        // R4: run of ones, two pulses per cell
        for (int c = 0; c < 60; c++) drive_cell(1'b1, 20, 0, 0, 1'b1, 1'b0);
        chk(locked_o, "R4 lock kept through ones", int'(locked_o), 1);

        // R5: slower cell rate with jitter
        for (int c = 0; c < 100; c++) begin
            int jc, jd;
            lf_step();
            jc = (int'(lf) % 5) - 2;
            lf_step();
            jd = (int'(lf) % 5) - 2;
            lf_step();
            drive_cell(lf[2], (c % 8 == 7) ? 21 : 20, jc, jd, 1'b1, 1'b0);
        end
        chk(locked_o, "R5 lock kept under offset and jitter", int'(locked_o), 1);

        // R6: silence
        quiet(50);
        chk(exp_q.size() == 0, "R3 every cell produced a bit", exp_q.size(), 0);
        chk(locked_o, "R6 lock kept over few missed windows", int'(locked_o), 1);
        quiet(200);
        chk(!locked_o, "R6 lock dropped after missed windows", int'(locked_o), 0);

        // R7: reacquisition needs a full new run
        preamble(200);
        chk(!locked_o, "R7 no early relock", int'(locked_o), 0);
        preamble(400);
        chk(locked_o, "R7 relock after full run", int'(locked_o), 1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual %0d expected %0d", cyc, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule